// File: doc/BRIEF.md
# NAND Flash Command Sequence Decoder

This block sits on the device side of a multiplexed flash bus. It watches chip enable, write enable, the two latch enables and the 8-bit I/O lines, which it samples on its own clock. Whenever write enable goes from low to high while chip enable is low, it takes one byte. Command bytes drive a small sequencer that knows which two-cycle commands are open. Address bytes fill a column register and a row register, and their positions depend on the command in progress. When a sequence ends legally, the block gives a one-cycle operation pulse with an operation code, and the column and row registers hold the address.

Bytes that are not in the command set, confirm bytes that do not fit the open command, and address counts that do not fit the command each produce a distinct one-cycle error pulse, and the open sequence is dropped. A busy input stands in for the array. While busy is high, only the reset and status commands get through. Every other byte is rejected or ignored.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is taken only on the first clock at which we_n is sampled high after being sampled low, and only if ce_n is low at that clock. It is a command when cle=1 and ale=0, and an address when ale=1 and cle=0. Any other combination, or a byte taken with ce_n high, has no effect.
- R2: These setup/confirm pairs issue an operation with op_code as shown: 00h/30h read (0), 00h/35h read for copy-back (1), 80h/10h page program (2), 80h/15h cache program (3), 85h/10h copy-back program (4), 60h/D0h block erase (5), 05h/E0h random data output (6).
- R3: 90h issues read-ID (8), FFh issues reset (9) and 70h issues status (10) straight away, with no confirm byte. Status leaves any open sequence intact.
- R4: While busy is high, any command byte other than FFh and 70h raises err_busy and changes nothing. Address bytes taken while busy are ignored.
- R5: A command byte outside the defined set raises err_undef and closes any open sequence.
- R6: A confirm byte (30h, 35h, 10h, 15h, D0h, E0h) that does not fit the open setup byte, or that arrives with no sequence open, raises err_seq and closes the sequence without an operation.
- R7: Read, program and copy-back expect four address bytes: column low, column high, row low, row high. Erase expects two bytes, row low then row high. Random data output expects two column bytes and keeps the row. A confirm that arrives after any other count raises err_addr and issues no operation. Extra bytes are not stored.
- R8: 85h after a complete four-byte program or copy-back address starts a random data input. The next two address bytes replace the column only. The second of them issues op_code 7, and the program stays open for its confirm.
- R9: FFh is accepted even while busy. It clears any partly received sequence, so a later confirm raises err_seq.
- R10: op_valid and the error pulses go high one clock after the capture clock and last one cycle. op_code, op_col and op_row hold their values between updates.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable; a byte is taken on its rising edge |
| cle | input | 1 | Marks a command byte |
| ale | input | 1 | Marks an address byte |
| io | input | 8 | Bus byte |
| busy | input | 1 | Array busy |
| op_valid | output | 1 | One-cycle pulse: operation decoded |
| op_code | output | 4 | Code of the last decoded operation |
| op_col | output | 16 | Column address register |
| op_row | output | 16 | Row address register |
| err_undef | output | 1 | Undefined command byte |
| err_seq | output | 1 | Confirm byte does not fit the open sequence |
| err_addr | output | 1 | Wrong address byte count at confirm |
| err_busy | output | 1 | Command rejected while busy |

## Verification
A wrong pending command or address count shows up at the latest on the next confirm byte. It then appears as a wrong operation code, an err_seq pulse or an err_addr pulse in place of the expected pulse, one clock after that byte is taken. A wrong byte position shows on op_col or op_row one clock after the address byte itself. The bench compares every output against its own model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder #(
  parameter int COL_CYC = 2,
  parameter int ROW_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   cle,
  input  logic                   ale,
  input  logic [7:0]             io,
  input  logic                   busy,
  output logic                   op_valid,
  output logic [3:0]             op_code,
  output logic [8*COL_CYC-1:0]   op_col,
  output logic [8*ROW_CYC-1:0]   op_row,
  output logic                   err_undef,
  output logic                   err_seq,
  output logic                   err_addr,
  output logic                   err_busy
);
  localparam int AW = COL_CYC + ROW_CYC;
  localparam int CW = $clog2(AW + 2);
  localparam logic [CW-1:0] K_COL = CW'(COL_CYC);
  localparam logic [CW-1:0] K_ROW = CW'(ROW_CYC);
  localparam logic [CW-1:0] K_ALL = CW'(AW);

  localparam logic [3:0] OP_READ = 4'd0, OP_READ_CB = 4'd1, OP_PROG = 4'd2,
    OP_CACHE = 4'd3, OP_CB_PROG = 4'd4, OP_ERASE = 4'd5, OP_ROUT = 4'd6,
    OP_RIN = 4'd7, OP_ID = 4'd8, OP_RESET = 4'd9, OP_STATUS = 4'd10;

  typedef enum logic [2:0] {P_NONE, P_READ, P_PROG, P_CBP, P_ERASE, P_ROUT} pend_t;

  pend_t         pend;
  logic          rin;
  logic [CW-1:0] cnt;
  logic          we_q;

  logic          cmd_ev, addr_ev, load_open, cfm_ok, to_row;
  logic [CW-1:0] need, idx;
  logic [3:0]    cfm_op;

  wire take = we_n & ~we_q & ~ce_n;
  assign cmd_ev    = take & cle & ~ale;
  assign addr_ev   = take & ale & ~cle;
  assign load_open = (pend == P_PROG || pend == P_CBP) && !rin && cnt == K_ALL;

  always_comb begin
    if (rin || pend == P_ROUT) need = K_COL;
    else if (pend == P_ERASE)  need = K_ROW;
    else                       need = K_ALL;
    to_row = (pend == P_ERASE) || (!rin && cnt >= K_COL);
    if (pend == P_ERASE)  idx = cnt;
    else if (to_row)      idx = cnt - K_COL;
    else                  idx = cnt;
  end

  always_comb begin
    cfm_ok = 1'b0;
    cfm_op = OP_READ;
    case (io)
      8'h30: begin cfm_ok = (pend == P_READ);  cfm_op = OP_READ;    end
      8'h35: begin cfm_ok = (pend == P_READ);  cfm_op = OP_READ_CB; end
      8'h10: begin
        cfm_ok = (pend == P_PROG) || (pend == P_CBP);
        cfm_op = (pend == P_CBP) ? OP_CB_PROG : OP_PROG;
      end
      8'h15: begin cfm_ok = (pend == P_PROG);  cfm_op = OP_CACHE;   end
      8'hD0: begin cfm_ok = (pend == P_ERASE); cfm_op = OP_ERASE;   end
      8'hE0: begin cfm_ok = (pend == P_ROUT);  cfm_op = OP_ROUT;    end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      pend      <= P_NONE;
      rin       <= 1'b0;
      cnt       <= '0;
      op_valid  <= 1'b0;
      op_code   <= '0;
      op_col    <= '0;
      op_row    <= '0;
      err_undef <= 1'b0;
      err_seq   <= 1'b0;
      err_addr  <= 1'b0;
      err_busy  <= 1'b0;
    end else begin
      we_q      <= we_n;
      op_valid  <= 1'b0;
      err_undef <= 1'b0;
      err_seq   <= 1'b0;
      err_addr  <= 1'b0;
      err_busy  <= 1'b0;
      if (cmd_ev) begin
        if (io == 8'hFF) begin
          op_valid <= 1'b1;
          op_code  <= OP_RESET;
          pend     <= P_NONE;
          rin      <= 1'b0;
          cnt      <= '0;
        end else if (io == 8'h70) begin
          op_valid <= 1'b1;
          op_code  <= OP_STATUS;
        end else if (busy) begin
          err_busy <= 1'b1;
        end else begin
          case (io)
            8'h00: begin pend <= P_READ;  rin <= 1'b0; cnt <= '0; end
            8'h80: begin pend <= P_PROG;  rin <= 1'b0; cnt <= '0; end
            8'h60: begin pend <= P_ERASE; rin <= 1'b0; cnt <= '0; end
            8'h05: begin pend <= P_ROUT;  rin <= 1'b0; cnt <= '0; end
            8'h85: begin
              if (load_open) begin
                rin <= 1'b1;
                cnt <= '0;
              end else begin
                pend <= P_CBP;
                rin  <= 1'b0;
                cnt  <= '0;
              end
            end
            8'h90: begin
              op_valid <= 1'b1;
              op_code  <= OP_ID;
              pend     <= P_NONE;
              rin      <= 1'b0;
              cnt      <= '0;
            end
            8'h30, 8'h35, 8'h10, 8'h15, 8'hD0, 8'hE0: begin
              if (!cfm_ok) err_seq <= 1'b1;
              else if (rin || cnt != need) err_addr <= 1'b1;
              else begin
                op_valid <= 1'b1;
                op_code  <= cfm_op;
              end
              pend <= P_NONE;
              rin  <= 1'b0;
              cnt  <= '0;
            end
            default: begin
              err_undef <= 1'b1;
              pend      <= P_NONE;
              rin       <= 1'b0;
              cnt       <= '0;
            end
          endcase
        end
      end else if (addr_ev && !busy && pend != P_NONE) begin
        if (cnt < need) begin
          for (int i = 0; i < COL_CYC; i++)
            if (!to_row && idx == CW'(i)) op_col[8*i +: 8] <= io;
          for (int i = 0; i < ROW_CYC; i++)
            if (to_row && idx == CW'(i)) op_row[8*i +: 8] <= io;
        end
        if (rin && cnt == K_COL - 1'b1) begin
          op_valid <= 1'b1;
          op_code  <= OP_RIN;
          rin      <= 1'b0;
          cnt      <= K_ALL;
        end else if (cnt <= need) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module nand_cmd_decoder_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       we_n,
  input logic       busy,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic       err_undef,
  input logic       err_seq,
  input logic       err_addr,
  input logic       err_busy
);
  assert_capture_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || err_undef || err_seq || err_addr || err_busy) |-> ($past(we_n) && !$past(we_n, 2)));

  assert_busy_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(busy)) |-> (op_code == 4'd9 || op_code == 4'd10));

  assert_busy_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |-> $past(busy));

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, err_undef, err_seq, err_addr, err_busy}));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_code <= 4'd10);
endmodule

bind nand_cmd_decoder nand_cmd_decoder_sva u_sva (.*);

// File: tb/nand_cmd_decoder_test.sv
module nand_cmd_decoder_test;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, cle = 0, ale = 0, busy = 0;
  logic [7:0] io = 0;
  logic op_valid, err_undef, err_seq, err_addr, err_busy;
  logic [3:0] op_code;
  logic [15:0] op_col, op_row;

  nand_cmd_decoder uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit running = 0;

  logic        x_valid = 0, x_undef = 0, x_seq = 0, x_addr = 0, x_busy = 0;
  logic [3:0]  x_code = 0;
  logic [15:0] x_col = 0, x_row = 0;
  int pend = 0;
  bit rin = 0;
  int aq[$];
  int rq[$];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("R10 op_valid", op_valid, x_valid);
    chk("R2 op_code", op_code, x_code);
    chk("R7 op_col", op_col, x_col);
    chk("R7 op_row", op_row, x_row);
    chk("R5 err_undef", err_undef, x_undef);
    chk("R6 err_seq", err_seq, x_seq);
    chk("R7 err_addr", err_addr, x_addr);
    chk("R4 err_busy", err_busy, x_busy);
  end

  function automatic int need();
    if (rin || pend == 5) return 2;
    if (pend == 4) return 2;
    return 4;
  endfunction

  task automatic emit(int code);
    x_valid = 1;
    x_code = code[3:0];
  endtask

  task automatic drop();
    pend = 0; rin = 0; aq.delete(); rq.delete();
  endtask

  task automatic model(bit c, bit a, bit cen, logic [7:0] b);
    int code;
    bit ok;
    if (cen || c == a) return;
    if (c) begin
      if (b == 8'hFF) begin emit(9); drop(); end
      else if (b == 8'h70) emit(10);
      else if (busy) x_busy = 1;
      else begin
        case (b)
          8'h00: begin drop(); pend = 1; end
          8'h80: begin drop(); pend = 2; end
          8'h60: begin drop(); pend = 4; end
          8'h05: begin drop(); pend = 5; end
          8'h85: if ((pend == 2 || pend == 3) && !rin && aq.size() == 4) begin
                   rin = 1; rq.delete();
                 end else begin drop(); pend = 3; end
          8'h90: begin emit(8); drop(); end
          8'h30, 8'h35, 8'h10, 8'h15, 8'hD0, 8'hE0: begin
            ok = 0; code = 0;
            if (b == 8'h30 && pend == 1) begin ok = 1; code = 0; end
            if (b == 8'h35 && pend == 1) begin ok = 1; code = 1; end
            if (b == 8'h10 && pend == 2) begin ok = 1; code = 2; end
            if (b == 8'h10 && pend == 3) begin ok = 1; code = 4; end
            if (b == 8'h15 && pend == 2) begin ok = 1; code = 3; end
            if (b == 8'hD0 && pend == 4) begin ok = 1; code = 5; end
            if (b == 8'hE0 && pend == 5) begin ok = 1; code = 6; end
            if (!ok) x_seq = 1;
            else if (rin || aq.size() != need()) x_addr = 1;
            else emit(code);
            drop();
          end
          default: begin x_undef = 1; drop(); end
        endcase
      end
    end else if (!busy && pend != 0) begin
      if (rin) begin
        rq.push_back(b);
        x_col[8*(rq.size()-1) +: 8] = b;
        if (rq.size() == 2) begin emit(7); rin = 0; end
      end else begin
        if (aq.size() < need()) begin
          if (pend == 4) x_row[8*aq.size() +: 8] = b;
          else if (aq.size() < 2) x_col[8*aq.size() +: 8] = b;
          else x_row[8*(aq.size()-2) +: 8] = b;
        end
        aq.push_back(b);
      end
    end
  endtask

  task automatic bus(bit cen, bit c, bit a, logic [7:0] b);
    @(negedge clk);
    ce_n = cen; cle = c; ale = a; io = b; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(posedge clk);
    model(c, a, cen, b);
    @(posedge clk);
    x_valid = 0; x_undef = 0; x_seq = 0; x_addr = 0; x_busy = 0;
  endtask

  task automatic cmd(logic [7:0] b);  bus(0, 1, 0, b); endtask
  task automatic adr(logic [7:0] b);  bus(0, 0, 1, b); endtask
  task automatic adr4(logic [7:0] a0, a1, a2, a3);
    adr(a0); adr(a1); adr(a2); adr(a3);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    running = 1;
    chk("R11 reset op_code", op_code, 0);
    chk("R11 reset op_row", op_row, 0);

    cmd(8'h00); adr4(8'h34, 8'h12, 8'h78, 8'h56); cmd(8'h30);
    chk("R2 read code", op_code, 0);
    chk("R7 read col", op_col, 16'h1234);
    chk("R7 read row", op_row, 16'h5678);

    cmd(8'h00); adr4(8'h01, 8'h02, 8'h03, 8'h04); cmd(8'h35);
    chk("R2 copy-back read code", op_code, 1);

    cmd(8'h80); adr4(8'h10, 8'h00, 8'h22, 8'h11);
    cmd(8'h85); adr(8'hAA); adr(8'h0B);
    chk("R8 random input code", op_code, 7);
    chk("R8 random input col", op_col, 16'h0BAA);
    cmd(8'h10);
    chk("R8 program after random input", op_code, 2);
    chk("R8 row kept", op_row, 16'h1122);

    cmd(8'h80); adr4(8'h00, 8'h00, 8'h01, 8'h00); cmd(8'h15);
    chk("R2 cache program", op_code, 3);

    cmd(8'h85); adr4(8'h05, 8'h00, 8'h40, 8'h00); cmd(8'h10);
    chk("R2 copy-back program", op_code, 4);

    cmd(8'h60); adr(8'hCD); adr(8'h03); cmd(8'hD0);
    chk("R2 erase code", op_code, 5);
    chk("R7 erase row", op_row, 16'h03CD);

    cmd(8'h05); adr(8'h44); adr(8'h07); cmd(8'hE0);
    chk("R7 random output col", op_col, 16'h0744);
    chk("R2 random output code", op_code, 6);

    cmd(8'h90); chk("R3 read id", op_code, 8);
    cmd(8'h70); chk("R3 status", op_code, 10);
    cmd(8'hFF); chk("R3 reset", op_code, 9);

    cmd(8'h42);
    cmd(8'h00); adr(8'h11); cmd(8'hA5); cmd(8'h30);
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'h30);
    cmd(8'hE0);

    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h30);
    cmd(8'h60); adr4(8'h01, 8'h02, 8'h03, 8'h04); cmd(8'hD0);
    cmd(8'h80); adr4(8'h01, 8'h02, 8'h03, 8'h04); cmd(8'h85); adr(8'h09); cmd(8'h10);

    cmd(8'h80); adr4(8'h0A, 8'h0B, 8'h0C, 8'h0D);
    cmd(8'h70);
    chk("R3 status keeps sequence", op_code, 10);
    cmd(8'h10);
    chk("R3 program after status", op_code, 2);

    @(negedge clk); busy = 1;
    cmd(8'h00); cmd(8'h90);
    chk("R4 busy rejects read id", op_code, 2);
    adr(8'hEE);
    chk("R4 address ignored when busy", op_row, 16'h0D0C);
    cmd(8'h70);
    chk("R4 status while busy", op_code, 10);
    @(negedge clk); busy = 0;

    cmd(8'h80); adr4(8'h01, 8'h00, 8'h02, 8'h00);
    @(negedge clk); busy = 1;
    cmd(8'hFF);
    chk("R9 reset while busy", op_code, 9);
    @(negedge clk); busy = 0;
    cmd(8'h10);

    bus(1, 1, 0, 8'h90);
    chk("R1 ce_n high ignored", op_code, 9);
    bus(0, 1, 1, 8'h90);
    bus(0, 0, 0, 8'h90);
    chk("R1 bad latch enables ignored", op_code, 9);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule